// File: doc/BRIEF.md
# Vector Index Multiply-Accumulate Unit

This unit is a small vector execution engine for sparse-by-dense matrix products. The dense operand is kept row by row in a local row file. A write port fills that file once per tile, outside the loop over nonzeros. Each operation then presents one nonzero of a sparse row: its signed value, its column index and an accumulator number. The column index is turned into a row-file address at run time. The addressed dense row is scaled lane by lane by the value, and the products are summed into the chosen accumulator. A single operation therefore stands in for a row load, a vector multiply and a vector add.

The host programs a tile window with three inputs: the first row-file entry of the tile, the first column the tile covers, and how many columns it covers. A column outside that window, or one whose row would fall past the end of the row file, raises a one-cycle error flag and leaves every accumulator as it was. A clear operation zeroes an accumulator before a new output row begins. A read port returns all lanes of an accumulator in one cycle. The pipeline has two stages: the indirect row read, then the multiply-add and write-back. An operation to an accumulator sees the result of the operation accepted one cycle earlier.

Top module: `vimac_unit`

## Requirements
- R1: A row-load write (`ld_en`, `ld_row`, `ld_data`) stores lane i of `ld_data` (bits [16i+15:16i]) as a signed 16-bit element of row-file entry `ld_row`. That entry is used by any later operation that maps to it.
- R2: An accepted non-clear operation with column c reads row-file entry e = `tile_base` + (c − `tile_col0`). For each lane i it adds `op_val` × row[e][i] into lane i of accumulator `op_acc`.
- R3: If c < `tile_col0`, c − `tile_col0` ≥ `tile_cols`, or e ≥ 16, the operation leaves all accumulators unchanged. `err_o` is then high for exactly one cycle, two cycles after the acceptance edge. `err_o` is never high otherwise.
- R4: An accepted operation with `op_clr`=1 sets every lane of accumulator `op_acc` to zero, whatever the column inputs hold. It never raises `err_o`, and the other accumulators keep their values.
- R5: Operations accepted on consecutive cycles to the same accumulator all take effect, each building on the result of the one before.
- R6: `op_ready` is low only when `ld_en` is high in the same cycle, targeting the entry that the presented non-clear, in-range operation would read. A stalled operation is accepted once the write is gone, and it uses the newly written row.
- R7: A read request (`rd_en`, `rd_acc`) returns, one cycle later, `rd_valid`=1 and all 8 lanes of the accumulator, lane i at bits [32i+31:32i]. `rd_valid` is 0 in any cycle that does not follow a request. The value returned is the one held before any write-back at the request's own edge.
- R8: After reset, `err_o` and `rd_valid` are low and every accumulator lane reads zero.
- R9: Products are signed 16×16 and are sign-extended into 32-bit accumulator lanes. Sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Row-file write strobe |
| ld_row | input | 4 | Row-file entry to write |
| ld_data | input | 128 | Eight signed 16-bit lanes |
| tile_base | input | 4 | Row-file entry holding the first column of the tile |
| tile_col0 | input | 8 | First column covered by the tile |
| tile_cols | input | 5 | Number of columns in the tile |
| op_valid | input | 1 | Operation presented |
| op_ready | output | 1 | Operation can be accepted this cycle |
| op_clr | input | 1 | Operation clears the accumulator instead |
| op_val | input | 16 | Signed nonzero value |
| op_col | input | 8 | Column index of the nonzero |
| op_acc | input | 2 | Destination accumulator |
| err_o | output | 1 | Out-of-tile column pulse |
| rd_en | input | 1 | Accumulator read request |
| rd_acc | input | 2 | Accumulator to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 256 | Eight signed 32-bit lanes |

## Verification
The hardest case to reach from the ports is the same-cycle collision: a row-load write landing on exactly the entry that an operation would read. The mapping is data-dependent, so the stimulus sets a non-zero base and column origin. It then drives an operation and a write to the computed entry in one cycle, checks that the operation is held off, and drops the write. The accumulator read afterwards must show the new row's data. Wrap-around is reached by loading a row of the most negative value and accumulating its square twice. Forwarding is reached by issuing long runs of operations on consecutive cycles to one accumulator.

// File: rtl/vimac_pkg.sv
package vimac_pkg;
  localparam int LANES = 8;
  localparam int DW    = 16;
  localparam int AW    = 32;
  localparam int NROWS = 16;
  localparam int NACC  = 4;
  localparam int IDXW  = 8;
  localparam int RIW   = $clog2(NROWS);
  localparam int AIW   = $clog2(NACC);
  localparam int LENW  = RIW + 1;

  typedef struct packed {
    logic            vld;
    logic            clr;
    logic            ok;
    logic [AIW-1:0]  acc;
    logic [DW-1:0]   val;
  } stage_t;
endpackage

// File: rtl/vimac_rowfile.sv
module vimac_rowfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 128,
  localparam int AB   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AB-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AB-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vimac_index.sv
module vimac_index #(
  parameter int IDXW  = 8,
  parameter int NROWS = 16,
  localparam int RIW  = $clog2(NROWS),
  localparam int LENW = RIW + 1
) (
  input  logic [IDXW-1:0] col,
  input  logic [RIW-1:0]  base,
  input  logic [IDXW-1:0] col0,
  input  logic [LENW-1:0] ncols,
  output logic [RIW-1:0]  entry,
  output logic            ok
);
  logic [IDXW:0]   off;
  logic [IDXW+1:0] sum;

  always_comb begin
    off   = {1'b0, col} - {1'b0, col0};
    sum   = (IDXW+2)'(base) + (IDXW+2)'(off[IDXW-1:0]);
    entry = sum[RIW-1:0];
    ok    = !off[IDXW]
            && ((IDXW+1)'(off[IDXW-1:0]) < (IDXW+1)'(ncols))
            && (sum < (IDXW+2)'(NROWS));
  end
endmodule

// File: rtl/vimac_mac.sv
module vimac_mac #(
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] acc_in,
  input  logic [LANES*DW-1:0] row,
  input  logic [DW-1:0]       val,
  input  logic                clr,
  output logic [LANES*AW-1:0] acc_out
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   prod_x;
    logic signed [AW-1:0]   sum;
    assign prod   = $signed(val) * $signed(row[i*DW +: DW]);
    assign prod_x = AW'(prod);
    assign sum    = $signed(acc_in[i*AW +: AW]) + prod_x;
    assign acc_out[i*AW +: AW] = clr ? '0 : sum;
  end
endmodule

// File: rtl/vimac_unit.sv
module vimac_unit
  import vimac_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_en,
  input  logic [RIW-1:0]      ld_row,
  input  logic [LANES*DW-1:0] ld_data,
  input  logic [RIW-1:0]      tile_base,
  input  logic [IDXW-1:0]     tile_col0,
  input  logic [LENW-1:0]     tile_cols,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic                op_clr,
  input  logic [DW-1:0]       op_val,
  input  logic [IDXW-1:0]     op_col,
  input  logic [AIW-1:0]      op_acc,
  output logic                err_o,
  input  logic                rd_en,
  input  logic [AIW-1:0]      rd_acc,
  output logic                rd_valid,
  output logic [LANES*AW-1:0] rd_data
);
  logic [RIW-1:0]      map_entry;
  logic                map_ok;
  logic                accept;
  logic [LANES*DW-1:0] row_q;
  logic [LANES*AW-1:0] mac_out;
  logic [LANES*AW-1:0] acc_q [NACC];
  stage_t              s2;

  vimac_index #(.IDXW(IDXW), .NROWS(NROWS)) idx_i (
    .col(op_col), .base(tile_base), .col0(tile_col0), .ncols(tile_cols),
    .entry(map_entry), .ok(map_ok)
  );

  // hold off an operation whose row is being rewritten this cycle
  assign op_ready = !(ld_en && !op_clr && map_ok && (ld_row == map_entry));
  assign accept   = op_valid && op_ready;

  vimac_rowfile #(.DEPTH(NROWS), .WIDTH(LANES*DW)) rf_i (
    .clk(clk), .we(ld_en), .waddr(ld_row), .wdata(ld_data),
    .re(accept && !op_clr && map_ok), .raddr(map_entry), .rdata(row_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2 <= '0;
    end else begin
      s2.vld <= accept;
      s2.clr <= op_clr;
      s2.ok  <= map_ok;
      s2.acc <= op_acc;
      s2.val <= op_val;
    end
  end

  // stage 2 reads the accumulator written at the previous edge: back-to-back forward
  vimac_mac #(.LANES(LANES), .DW(DW), .AW(AW)) mac_i (
    .acc_in(acc_q[s2.acc]), .row(row_q), .val(s2.val), .clr(s2.clr),
    .acc_out(mac_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NACC; k++) acc_q[k] <= '0;
      err_o    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (s2.vld && (s2.clr || s2.ok)) acc_q[s2.acc] <= mac_out;
      err_o    <= s2.vld && !s2.clr && !s2.ok;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= acc_q[rd_acc];
    end
  end
endmodule

// File: rtl/vimac_chk.sv
module vimac_chk #(
  parameter int IDXW  = 8,
  parameter int RIW   = 4,
  parameter int NROWS = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            ld_en,
  input logic [RIW-1:0]  ld_row,
  input logic [RIW-1:0]  tile_base,
  input logic [IDXW-1:0] tile_col0,
  input logic [RIW:0]    tile_cols,
  input logic            op_valid,
  input logic            op_ready,
  input logic            op_clr,
  input logic [IDXW-1:0] op_col,
  input logic            err_o,
  input logic            rd_en,
  input logic            rd_valid
);
  int unsigned c_off;
  int unsigned c_ent;
  logic        c_in;
  always_comb begin
    c_off = int'(op_col) - int'(tile_col0);
    c_ent = int'(tile_base) + c_off;
    c_in  = (op_col >= tile_col0) && (c_off < int'(tile_cols)) && (c_ent < NROWS);
  end

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (!err_o && !rd_valid));

  assert_read_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_read_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  assert_err_below_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready && !op_clr && (op_col < tile_col0)) |=> ##1 err_o);

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(op_valid && op_ready && !op_clr, 2));

  assert_clear_noerr_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready && op_clr) |=> ##1 !err_o);

  assert_stall_cause_R6: assert property (@(posedge clk) disable iff (rst)
    !op_ready |-> ld_en);

  assert_no_collide_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready && !op_clr && ld_en && c_in) |-> (ld_row != RIW'(c_ent)));
endmodule

bind vimac_unit vimac_chk #(.IDXW(vimac_pkg::IDXW), .RIW(vimac_pkg::RIW),
                            .NROWS(vimac_pkg::NROWS)) chk_i (
  .clk(clk), .rst(rst), .ld_en(ld_en), .ld_row(ld_row),
  .tile_base(tile_base), .tile_col0(tile_col0), .tile_cols(tile_cols),
  .op_valid(op_valid), .op_ready(op_ready), .op_clr(op_clr), .op_col(op_col),
  .err_o(err_o), .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/vimac_unit_tb_top.sv
module vimac_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ld_en = 1'b0;
  logic [3:0]   ld_row = '0;
  logic [127:0] ld_data = '0;
  logic [3:0]   tile_base = '0;
  logic [7:0]   tile_col0 = '0;
  logic [4:0]   tile_cols = 5'd16;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic         op_clr = 1'b0;
  logic [15:0]  op_val = '0;
  logic [7:0]   op_col = '0;
  logic [1:0]   op_acc = '0;
  logic         err_o;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_acc = '0;
  logic         rd_valid;
  logic [255:0] rd_data;

  int tests = 0;
  int fails = 0;
  logic signed [15:0] m_row [16][8];
  logic signed [31:0] m_acc [4][8];

  always #10 clk = ~clk;

  vimac_unit dut_i (.*);

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] pat(input int r, input int l);
    if (r == 15) return 16'sh8000;
    return 16'(r * 1013 - l * 777 + 3);
  endfunction

  task automatic load(input int r);
    ld_en = 1'b1;
    ld_row = 4'(r);
    for (int l = 0; l < 8; l++) begin
      ld_data[l*16 +: 16] = m_row[r][l];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic bit in_tile(input int c, output int e);
    int off = c - int'(tile_col0);
    e = int'(tile_base) + off;
    return (off >= 0) && (off < int'(tile_cols)) && (e < 16);
  endfunction

  task automatic op(input logic signed [15:0] v, input int c, input int a, input bit clr);
    int e;
    op_valid = 1'b1; op_val = v; op_col = 8'(c); op_acc = 2'(a); op_clr = clr;
    #1;
    while (!op_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    op_valid = 1'b0; op_clr = 1'b0;
    if (clr) begin
      for (int l = 0; l < 8; l++) m_acc[a][l] = '0;
    end else if (in_tile(c, e)) begin
      for (int l = 0; l < 8; l++) m_acc[a][l] = m_acc[a][l] + 32'(int'(v) * int'(m_row[e][l]));
    end
  endtask

  task automatic rd_chk(input int a, input string req);
    logic [255:0] exp;
    @(negedge clk);
    rd_en = 1'b1; rd_acc = 2'(a);
    @(negedge clk);
    rd_en = 1'b0;
    for (int l = 0; l < 8; l++) exp[l*32 +: 32] = m_acc[a][l];
    chk({req, " R7 valid"}, {255'd0, rd_valid}, 256'd1);
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++)
      for (int l = 0; l < 8; l++) m_row[r][l] = pat(r, l);
    for (int a = 0; a < 4; a++)
      for (int l = 0; l < 8; l++) m_acc[a][l] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: quiet outputs and zero accumulators after reset
    chk("R8 err_o", {255'd0, err_o}, 256'd0);
    chk("R8 rd_valid", {255'd0, rd_valid}, 256'd0);
    for (int a = 0; a < 4; a++) rd_chk(a, "R8 acc zero");

    // R1: fill the row file
    for (int r = 0; r < 16; r++) load(r);

    // R2, R5, R9: full-tile sweep, back-to-back operations per accumulator
    tile_base = 4'd0; tile_col0 = 8'd0; tile_cols = 5'd16;
    for (int a = 0; a < 4; a++) begin
      op(16'sd0, 0, a, 1'b1);
      for (int c = 0; c < 16; c++)
        op(16'(c * 301 - a * 4099 - 7), c, a, 1'b0);
    end
    for (int a = 0; a < 4; a++) rd_chk(a, "R2 R5 sweep");

    // R9: wrap at 2^31 from two products of -32768 squared
    op(16'sd0, 0, 1, 1'b1);
    op(16'sh8000, 15, 1, 1'b0);
    op(16'sh8000, 15, 1, 1'b0);
    rd_chk(1, "R9 wrap");

    // R2: offset mapping, base 4, tile columns 100..107
    tile_base = 4'd4; tile_col0 = 8'd100; tile_cols = 5'd8;
    op(16'sd0, 0, 0, 1'b1);
    for (int c = 100; c < 108; c++) op(16'(c - 90), c, 0, 1'b0);
    rd_chk(0, "R2 offset map");

    // R3: out of tile below, above, past the row file
    op(16'sd9, 99, 0, 1'b0);
    chk("R3 err timing early", {255'd0, err_o}, 256'd0);
    @(negedge clk);
    chk("R3 err below", {255'd0, err_o}, 256'd1);
    @(negedge clk);
    chk("R3 err single", {255'd0, err_o}, 256'd0);
    op(16'sd9, 108, 0, 1'b0);
    @(negedge clk);
    chk("R3 err above", {255'd0, err_o}, 256'd1);
    tile_base = 4'd12; tile_col0 = 8'd0; tile_cols = 5'd8;
    op(16'sd9, 5, 0, 1'b0);
    @(negedge clk);
    chk("R3 err past file", {255'd0, err_o}, 256'd1);
    op(16'sd9, 3, 0, 1'b0);
    @(negedge clk);
    chk("R3 no err in range", {255'd0, err_o}, 256'd0);
    rd_chk(0, "R3 acc unchanged");

    // R4: clear one accumulator, another keeps its value, no error
    op(16'sd0, 200, 2, 1'b1);
    @(negedge clk);
    chk("R4 clear no err", {255'd0, err_o}, 256'd0);
    rd_chk(2, "R4 cleared");
    rd_chk(3, "R4 other kept");

    // R6: same-cycle write to the entry the operation maps to
    tile_base = 4'd3; tile_col0 = 8'd50; tile_cols = 5'd10;
    op(16'sd0, 0, 3, 1'b1);
    for (int l = 0; l < 8; l++) m_row[8][l] = 16'(l * 1111 - 4000);
    ld_en = 1'b1; ld_row = 4'd8;
    for (int l = 0; l < 8; l++) ld_data[l*16 +: 16] = m_row[8][l];
    op_valid = 1'b1; op_val = 16'sd3; op_col = 8'd55; op_acc = 2'd3; op_clr = 1'b0;
    #1;
    chk("R6 stall", {255'd0, op_ready}, 256'd0);
    ld_row = 4'd9;
    #1;
    chk("R6 other row no stall", {255'd0, op_ready}, 256'd1);
    ld_row = 4'd8;
    @(negedge clk);
    ld_en = 1'b0;
    op(16'sd3, 55, 3, 1'b0);
    rd_chk(3, "R6 new row used");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule